// File: doc/BRIEF.md
# Nested Prioritized Event Controller

This block collects event requests for a processor core and decides which one the core should service next. It works in two stages. The routing stage takes `NSRC` peripheral request lines and sends each one to one of the general-purpose levels 7 to 13. Each source has a 4-bit field that selects its level; the fields can be rewritten and return to a fixed default at reset. The core stage holds sixteen fixed-priority levels, numbered 0 to 15, with 0 the most urgent. Levels 0 to 6 are tied to dedicated event classes. Level 0 is emulation, level 1 is a reset event and level 2 is the non-maskable event. Level 3 is a synchronous exception, level 4 is a slot that never fires, level 5 is a hardware error and level 6 is the core timer.

The controller keeps one pending bit and one active bit for each level. It presents the most urgent pending, enabled level, but only when that level outranks every level already in service, so service can nest. The core acknowledges the presented level when it enters the handler and pulses a return signal when it leaves. A small register port holds the enable mask, the software raise bits, a combined view of the pending and active bits, and the routing fields.

Top module: `nest_evt_ctrl`

## Requirements
- R1: After reset the pending, active and mask bits are all zero and `evt_valid_o` is low. Routing field k holds k mod 7, so with eight sources the word at address 4 reads 32'h06543210.
- R2: `evt_valid_o` is high exactly when some pending, enabled level has a lower number than every active level. `evt_level_o` then gives the lowest-numbered such level.
- R3: A request that is high at a clock edge sets that level's pending bit, and the bit stays set while the level is masked. When the core acknowledges the level, the pending bit clears only if none of that level's request sources is high at the same edge.
- R4: Levels 0 to 3 are always enabled and level 4 is never presented. Levels 5 to 15 are enabled by bits 5 to 15 of the mask register at address 0. Writes to bits 0 to 4 of that register are dropped, so it reads back with those bits at zero.
- R5: `ack_i` while `evt_valid_o` is high sets the active bit of the presented level and clears its pending bit. `ret_i` clears the lowest-numbered active bit. Address 2 reads the active bits in [31:16] and the pending bits in [15:0].
- R6: Level 2 becomes pending when either `nmi_pin_i` or `wdog_req_i` is high.
- R7: Source k is routed by the 4-bit field at bits [4*(k mod 8)+3 : 4*(k mod 8)] of the word at address 4 + k/8. A field value v selects level 7+v, and any value above 6 selects level 13. When several sources share a level, their requests are ORed.
- R8: Writing a one to bit l of address 1, for l from 7 to 15, sets pending bit l. Ones written to bits 0 to 6 of that address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| emu_req_i | input | 1 | Emulation event request (level 0) |
| rst_evt_req_i | input | 1 | Reset event request (level 1) |
| nmi_pin_i | input | 1 | External non-maskable request (level 2) |
| wdog_req_i | input | 1 | Watchdog timeout request (level 2) |
| exc_req_i | input | 1 | Synchronous exception request (level 3) |
| hwerr_req_i | input | 1 | Hardware error request (level 5) |
| tmr_req_i | input | 1 | Core timer request (level 6) |
| src_req_i | input | NSRC | Peripheral request lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | AW | Register read address |
| rd_data_o | output | 32 | Register read data, combinational |
| ack_i | input | 1 | Core has entered the presented level |
| ret_i | input | 1 | Core returns from its most urgent active level |
| evt_valid_o | output | 1 | A level is being presented |
| evt_level_o | output | 4 | Number of the presented level |

## Verification
The hardest state to reach is deep nesting. Here a low-priority level is active and must hold back a newly raised level below it, while a more urgent level is still allowed to preempt. Only a sequence of raise, acknowledge and return steps produces this state, with each raise made before the matching return. Directed steps build a three-deep stack out of software raises, a routed peripheral and the timer. A pseudo-random phase then mixes acknowledge, return, routing rewrites and mask changes. A behavioural model in the bench checks the presented level and both bit vectors on every cycle.

// File: rtl/nest_evt_ctrl.sv
module nest_evt_ctrl #(
  parameter int NSRC = 8,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            emu_req_i,
  input  logic            rst_evt_req_i,
  input  logic            nmi_pin_i,
  input  logic            wdog_req_i,
  input  logic            exc_req_i,
  input  logic            hwerr_req_i,
  input  logic            tmr_req_i,
  input  logic [NSRC-1:0] src_req_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [31:0]     wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [31:0]     rd_data_o,
  input  logic            ack_i,
  input  logic            ret_i,
  output logic            evt_valid_o,
  output logic [3:0]      evt_level_o
);
  localparam int NLVL = 16;
  localparam logic [15:0] MASK_WR = 16'hFFE0;
  localparam logic [15:0] SW_WR   = 16'hFF80;
  localparam logic [AW-1:0] A_MASK = AW'(0);
  localparam logic [AW-1:0] A_SWR  = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);
  localparam int A_ASG = 4;

  logic [NLVL-1:0] mask_q, pend_q, act_q;
  logic [3:0]      asg_q [NSRC];
  logic [NLVL-1:0] hw_req, elig, en, sw_set, ack_vec, ret_vec;
  logic [3:0]      win, amin;
  logic            ack_fire;

  function automatic logic [3:0] lvl_of(input logic [3:0] f);
    return (f > 4'd6) ? 4'd13 : 4'd7 + f;
  endfunction

  always_comb begin
    hw_req    = '0;
    hw_req[0] = emu_req_i;
    hw_req[1] = rst_evt_req_i;
    hw_req[2] = nmi_pin_i | wdog_req_i;
    hw_req[3] = exc_req_i;
    hw_req[5] = hwerr_req_i;
    hw_req[6] = tmr_req_i;
    for (int k = 0; k < NSRC; k++)
      if (src_req_i[k]) hw_req[lvl_of(asg_q[k])] = 1'b1;
  end

  assign en   = {mask_q[15:5], 1'b0, 4'hF};
  assign elig = pend_q & en;

  always_comb begin
    win  = 4'd0;
    amin = 4'd0;
    for (int l = NLVL - 1; l >= 0; l--) begin
      if (elig[l])  win  = 4'(l);
      if (act_q[l]) amin = 4'(l);
    end
  end

  assign evt_valid_o = (|elig) && (act_q == '0 || win < amin);
  assign evt_level_o = win;

  assign ack_fire = ack_i & evt_valid_o;
  assign ack_vec  = ack_fire ? (16'd1 << win) : '0;
  assign ret_vec  = (ret_i && act_q != '0) ? (16'd1 << amin) : '0;
  assign sw_set   = (wr_en_i && wr_addr_i == A_SWR) ? (wr_data_i[15:0] & SW_WR) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~ack_vec) | hw_req | sw_set;
      act_q  <= (act_q & ~ret_vec) | ack_vec;
      if (wr_en_i && wr_addr_i == A_MASK) mask_q <= wr_data_i[15:0] & MASK_WR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NSRC; k++) asg_q[k] <= 4'(k % 7);
    end else if (wr_en_i) begin
      for (int k = 0; k < NSRC; k++)
        if (wr_addr_i == AW'(A_ASG + k / 8)) asg_q[k] <= wr_data_i[4*(k%8) +: 4];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_MASK) rd_data_o[15:0] = mask_q;
    if (rd_addr_i == A_STAT) rd_data_o = {act_q, pend_q};
    for (int k = 0; k < NSRC; k++)
      if (rd_addr_i == AW'(A_ASG + k / 8)) rd_data_o[4*(k%8) +: 4] = asg_q[k];
  end

  assert_no_slot4_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_o |-> evt_level_o != 4'd4);

  assert_unmaskable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[3:0] != 4'd0 && act_q == '0) |-> evt_valid_o);

  assert_outranks_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_o |-> ((17'(act_q) & ((17'd1 << (evt_level_o + 5'd1)) - 17'd1)) == 17'd0));

  assert_ack_sets_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && evt_valid_o) |=> act_q[$past(evt_level_o)]);

  assert_ret_pops_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !(ack_i && evt_valid_o) && act_q != '0)
      |=> $countones(act_q) + 1 == $past($countones(act_q)));

  assert_nmi_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pin_i || wdog_req_i) |=> pend_q[2]);
endmodule

// File: tb/test_nest_evt_ctrl.sv
module test_nest_evt_ctrl;
  localparam int PERIOD = 10;
  localparam int NSRC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic emu = 0, rsev = 0, nmi = 0, wdog = 0, exc = 0, hwerr = 0, tmr = 0;
  logic [NSRC-1:0] src = '0;
  logic wr_en = 0;
  logic [3:0] wr_addr = '0, rd_addr = 4'd2;
  logic [31:0] wr_data = '0;
  logic ack = 0, ret = 0;
  logic [31:0] rd_data;
  logic evt_valid;
  logic [3:0] evt_level;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  nest_evt_ctrl #(.NSRC(NSRC), .AW(4)) i_nest_evt_ctrl (
    .clk(clk), .rst_n(rst_n), .emu_req_i(emu), .rst_evt_req_i(rsev),
    .nmi_pin_i(nmi), .wdog_req_i(wdog), .exc_req_i(exc), .hwerr_req_i(hwerr),
    .tmr_req_i(tmr), .src_req_i(src), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ack_i(ack), .ret_i(ret), .evt_valid_o(evt_valid), .evt_level_o(evt_level));

  bit [15:0] m_pend, m_act, m_mask;
  int m_asg [NSRC];

  function automatic bit m_en(int l);
    if (l < 4) return 1;
    if (l == 4) return 0;
    return m_mask[l];
  endfunction

  function automatic int m_win();
    for (int l = 0; l < 16; l++) if (m_pend[l] && m_en(l)) return l;
    return -1;
  endfunction

  function automatic int m_amin();
    for (int l = 0; l < 16; l++) if (m_act[l]) return l;
    return 16;
  endfunction

  function automatic bit m_valid();
    int w = m_win();
    return w >= 0 && w < m_amin();
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_act = 0; m_mask = 0;
      for (int k = 0; k < NSRC; k++) m_asg[k] = k % 7;
    end else begin
      bit [15:0] req;
      int w, am;
      bit v;
      w = m_win(); am = m_amin(); v = m_valid();
      req = 0;
      req[0] = emu; req[1] = rsev; req[2] = nmi | wdog; req[3] = exc;
      req[5] = hwerr; req[6] = tmr;
      for (int k = 0; k < NSRC; k++)
        if (src[k]) req[(m_asg[k] > 6) ? 13 : 7 + m_asg[k]] = 1;
      if (ret && am < 16) m_act[am] = 0;
      if (ack && v) begin m_act[w] = 1; m_pend[w] = 0; end
      m_pend = m_pend | req;
      if (wr_en) begin
        if (wr_addr == 1) for (int l = 7; l < 16; l++) if (wr_data[l]) m_pend[l] = 1;
        if (wr_addr == 0) m_mask = wr_data[15:0] & 16'hFFE0;
        if (wr_addr == 4) for (int k = 0; k < NSRC; k++) m_asg[k] = int'(wr_data[4*k +: 4]);
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 valid", int'(evt_valid), int'(m_valid()));
      if (m_valid()) chk("R2 level", int'(evt_level), m_win());
      if (rd_addr == 4'd2) begin
        chk("R3 pending", int'(rd_data[15:0]), int'(m_pend));
        chk("R5 active", int'(rd_data[31:16]), int'(m_act));
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1; wr_addr = 4'(a); wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    rd_addr = 4'(a);
    @(negedge clk); #1;
    chk(tag, int'(rd_data), exp);
    tick();
    rd_addr = 4'd2;
  endtask

  task automatic ackp();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic retp();
    ret = 1; tick(); ret = 0;
  endtask

  task automatic drain();
    repeat (40) begin
      if (m_valid()) ack = 1;
      else if (m_act != 0) ret = 1;
      tick();
      ack = 0; ret = 0;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    chk("R1 valid low", int'(evt_valid), 0);
    rd_chk("R1 mask", 0, 0);
    rd_chk("R1 routing", 4, 32'h06543210);
    rd_chk("R1 status", 2, 0);

    wr(0, 32'hFFFF_FFFF);
    rd_chk("R4 mask readback", 0, 32'h0000FFE0);

    tmr = 1; tick(); tmr = 0;
    chk("R2 timer presented", int'(evt_level), 6);
    ackp();
    chk("R5 active6", int'(rd_data[22]), 1);
    retp();
    chk("R5 ret clears", int'(rd_data[31:16]), 0);

    wr(1, 32'h8000);
    chk("R8 sw15", int'(evt_level), 15);
    ackp();
    src[0] = 1; tick(); src[0] = 0;
    chk("R2 preempt 7", int'(evt_level), 7);
    ackp();
    wr(1, 32'h4000);
    chk("R2 14 held back", int'(evt_valid), 0);
    tmr = 1; tick(); tmr = 0;
    chk("R2 timer nests", int'(evt_level), 6);
    ackp();
    chk("R5 three deep", int'(rd_data[31:16]), 16'h80C0);
    retp();
    retp();
    chk("R2 14 after return", int'(evt_level), 14);
    drain();

    wr(0, 0);
    src[1] = 1; tick(); src[1] = 0;
    repeat (3) tick();
    chk("R3 masked latch", int'(rd_data[8]), 1);
    chk("R4 masked silent", int'(evt_valid), 0);
    wr(0, 32'hFFE0);
    chk("R4 enabled", int'(evt_level), 8);
    drain();

    src[2] = 1; tick();
    ackp();
    chk("R3 held after ack", int'(rd_data[9]), 1);
    src[2] = 0;
    drain();

    wr(1, 32'h007F);
    chk("R8 low bits ignored", int'(rd_data[6:0]), 0);

    wr(4, 32'h06543219);
    src[0] = 1; tick(); src[0] = 0;
    chk("R7 clamp 13", int'(rd_data[13]), 1);
    chk("R7 not 7", int'(rd_data[7]), 0);
    src[6] = 1; tick();
    ackp();
    chk("R7 shared level held", int'(rd_data[13]), 1);
    src[6] = 0;
    drain();

    wdog = 1; tick(); wdog = 0;
    chk("R6 watchdog", int'(evt_level), 2);
    drain();
    nmi = 1; tick(); nmi = 0;
    chk("R6 pin", int'(evt_level), 2);
    drain();

    wr(0, 0);
    exc = 1; tick(); exc = 0;
    chk("R4 exception unmaskable", int'(evt_level), 3);
    drain();
    wr(0, 32'hFFE0);

    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      emu   = (lf[3:0] == 4'h1);
      rsev  = (lf[3:0] == 4'h2);
      exc   = (lf[3:0] == 4'h3);
      nmi   = (lf[7:4] == 4'h5);
      hwerr = (lf[7:4] == 4'h6);
      tmr   = (lf[11:8] == 4'h7);
      src   = lf[15:8] & {lf[2:0], lf[7:3]};
      ack   = lf[9];
      ret   = lf[12] & lf[1];
      wr_en = (lf[6:2] == 5'h0A);
      wr_addr = (lf[15]) ? 4'd1 : (lf[14] ? 4'd4 : 4'd0);
      wr_data = {lf, lf ^ 16'h5A5A};
      tick();
    end
    {emu, rsev, exc, nmi, hwerr, tmr, ack, ret, wr_en} = '0;
    src = '0;
    drain();
    chk("R5 stack empty", int'(rd_data[31:16]), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule